// File: doc/BRIEF.md
# Tile-Mapped Video Pixel Pipeline

This block produces the pixel stream for a character-mapped display. The screen is divided into 8 by 8 pixel cells. A tile map stores one tile number per cell. That tile number, together with the pixel row inside the cell, addresses four pattern memories. There is one memory for each colour plane: red, green, blue and intensity. Each memory returns one byte, which is loaded into its own 8-bit shift register. The shift registers then give one bit per dot clock. The four bits together form a 4-bit RGBI pixel. Because of this, each memory is read only once per 8 pixels.

The pipeline runs two tile periods ahead of the beam. The tile map is read two tile periods before a cell is shown. The pattern memories are read one tile period before. All four shift registers load in parallel on the last dot of every tile period. The block also contains its own dot counter, tile-column counter and scanline counter. The tile-column counter wraps by decoding only its two top bits, so a line is three halves of the active width.

Two small state machines follow the counters. The horizontal machine has the states H_ACT, H_FRONT, H_SYNC and H_BACK, and it changes state only at tile boundaries. Its transitions are:
- H_ACT to H_FRONT after the last active tile.
- H_FRONT to H_SYNC after HS_START tiles.
- H_SYNC to H_BACK after HS_TILES tiles.
- H_BACK to H_ACT when the column counter wraps.

The vertical machine has the states V_ACT, V_FRONT, V_SYNC and V_BACK, and it changes state only at line ends. Its transitions are:
- V_ACT to V_FRONT after the last active line.
- V_FRONT to V_SYNC after VS_START lines.
- V_SYNC to V_BACK after VS_LINES lines.
- V_BACK to V_ACT at the end of the frame.

A host writes the tile map and the pattern memories through simple synchronous write ports.

Top module: `tile_video_pipe`

## Requirements
- R1: While reset is held, and on the first dot after it is released, rgbi is 0, hsync is 0, vsync is 0 and blank is 0. The beam then starts at line 0, tile column 0, dot 0.
- R2: A line lasts 3·2^(COL_BITS-1) tile periods of 8 dots each. blank is low only in tile columns 0 to 2^COL_BITS-1 of active lines.
- R3: hsync is high in exactly the tile columns from 2^COL_BITS+HS_START up to, but not including, 2^COL_BITS+HS_START+HS_TILES, on every line.
- R4: A frame lasts VTOT_LINES lines. Lines 0 to 8·2^ROW_BITS-1 are active, and blank is high on every other line. vsync is high on lines 8·2^ROW_BITS+VS_START up to, but not including, 8·2^ROW_BITS+VS_START+VS_LINES.
- R5: On an active dot at line L, tile column C and dot D, the pixel is built as follows:
  - Let T be the tile-map entry at address {L>>3, C}.
  - rgbi bit k equals bit 7-D of the plane-k pattern byte at address {T, L[2:0]}.
  - The planes are 3 = red, 2 = green, 1 = blue and 0 = intensity, so pattern bit 7 is the leftmost pixel of a cell.
- R6: rgbi is 0 on every dot where blank is high.
- R7: A tile-map write sets entry {row, column} (map_addr = row·2^COL_BITS + column) to map_data. If the write comes after the cell's last fetch in a frame, it leaves that frame's picture unchanged and is shown from the next frame on.
- R8: A pattern write sets the byte at {tile, pixel row} (pat_addr = tile·8 + row) of plane pat_plane to pat_data. The plane coding is the same as in R5. If the write comes after the byte's last fetch in a frame, it leaves that frame unchanged and is shown from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| map_we | input | 1 | Tile-map write strobe |
| map_addr | input | ROW_BITS+COL_BITS | Tile-map cell address, {row, column} |
| map_data | input | TILE_BITS | Tile number to store |
| pat_we | input | 1 | Pattern write strobe |
| pat_plane | input | 2 | Plane select: 3 red, 2 green, 1 blue, 0 intensity |
| pat_addr | input | TILE_BITS+3 | Pattern address, {tile, pixel row} |
| pat_data | input | 8 | Pattern byte, bit 7 is the leftmost pixel |
| rgbi | output | 4 | Pixel colour {R, G, B, I} |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the active picture |

## Verification
A host write to a memory can land in the same cycle that the display fetch is streaming from that memory. The bench provokes this on line 28 of a checked frame. It rewrites a tile-map cell in row 0 and a green pattern byte for pixel row 1. Both are resources the running frame has already finished reading. The scoreboard then requires two things: the rest of that frame matches the old contents dot for dot, and the following frame shows the new contents. Separately, hsync and vsync are both high during the vertical sync lines, and each is compared on every dot against its own window.

// File: rtl/vid_pkg.sv
package vid_pkg;
    localparam int NPLANES  = 4;
    localparam int TILE_PX  = 8;
    localparam int DOT_BITS = 3;

    typedef enum logic [1:0] {
        H_ACT   = 2'd0,
        H_FRONT = 2'd1,
        H_SYNC  = 2'd2,
        H_BACK  = 2'd3
    } hphase_t;

    typedef enum logic [1:0] {
        V_ACT   = 2'd0,
        V_FRONT = 2'd1,
        V_SYNC  = 2'd2,
        V_BACK  = 2'd3
    } vphase_t;
endpackage

// File: rtl/vid_timing.sv
module vid_timing
    import vid_pkg::*;
#(
    parameter int COL_BITS   = 6,
    parameter int ROW_BITS   = 5,
    parameter int VTOT_LINES = 288,
    parameter int HS_START   = 2,
    parameter int HS_TILES   = 12,
    parameter int VS_START   = 4,
    parameter int VS_LINES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    output logic                tile_end,
    output logic                h_act,
    output logic                v_act,
    output logic                hsync,
    output logic                vsync,
    output logic [COL_BITS-1:0] fetch_col,
    output logic [ROW_BITS-1:0] fetch_trow,
    output logic [2:0]          fetch_prow
);
    localparam int HC_W = COL_BITS + 1;
    localparam int HACT = 1 << COL_BITS;
    localparam int HTOT = 3 << (COL_BITS - 1);
    localparam int VACT = TILE_PX << ROW_BITS;
    localparam int VC_W = $clog2(VTOT_LINES);

    logic [DOT_BITS-1:0] dot;
    logic [HC_W-1:0]     hc;
    logic [HC_W-1:0]     hc_inc;
    logic [VC_W-1:0]     vc;
    logic [VC_W-1:0]     vc_nx;
    logic [VC_W-1:0]     ln_fetch;
    logic                line_end;
    logic                frame_end;
    logic                near_end;
    hphase_t             hst, hst_nx;
    vphase_t             vst, vst_nx;

    // counter decode; the column chain wraps on its two top bits only
    always_comb begin
        tile_end  = (dot == DOT_BITS'(TILE_PX - 1));
        hc_inc    = hc + HC_W'(1);
        line_end  = tile_end && (hc_inc[HC_W-1:HC_W-2] == 2'b11);
        frame_end = line_end && (vc == VC_W'(VTOT_LINES - 1));
        vc_nx     = (vc == VC_W'(VTOT_LINES - 1)) ? '0 : vc + VC_W'(1);
        near_end  = (hc >= HC_W'(HTOT - 2));
    end

    // fetch position runs two tile periods ahead of the beam
    always_comb begin
        fetch_col  = near_end ? COL_BITS'(hc[0]) : hc[COL_BITS-1:0] + COL_BITS'(2);
        ln_fetch   = near_end ? vc_nx : vc;
        fetch_trow = ROW_BITS'(ln_fetch >> 3);
        fetch_prow = ln_fetch[2:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dot <= '0;
            hc  <= '0;
            vc  <= '0;
        end else begin
            dot <= dot + DOT_BITS'(1);
            if (tile_end) begin
                hc <= (hc_inc[HC_W-1:HC_W-2] == 2'b11) ? '0 : hc_inc;
            end
            if (line_end) begin
                vc <= vc_nx;
            end
        end
    end

    // state register for both phase machines
    always_ff @(posedge clk) begin
        if (rst) begin
            hst <= H_ACT;
            vst <= V_ACT;
        end else begin
            hst <= hst_nx;
            vst <= vst_nx;
        end
    end

    always_comb begin
        hst_nx = hst;
        if (tile_end) begin
            unique case (hst)
                H_ACT:   if (hc == HC_W'(HACT - 1)) hst_nx = H_FRONT;
                H_FRONT: if (hc == HC_W'(HACT + HS_START - 1)) hst_nx = H_SYNC;
                H_SYNC:  if (hc == HC_W'(HACT + HS_START + HS_TILES - 1)) hst_nx = H_BACK;
                H_BACK:  if (line_end) hst_nx = H_ACT;
            endcase
        end
    end

    always_comb begin
        vst_nx = vst;
        if (line_end) begin
            unique case (vst)
                V_ACT:   if (vc == VC_W'(VACT - 1)) vst_nx = V_FRONT;
                V_FRONT: if (vc == VC_W'(VACT + VS_START - 1)) vst_nx = V_SYNC;
                V_SYNC:  if (vc == VC_W'(VACT + VS_START + VS_LINES - 1)) vst_nx = V_BACK;
                V_BACK:  if (frame_end) vst_nx = V_ACT;
            endcase
        end
    end

    // output process
    always_comb begin
        h_act = (hst == H_ACT);
        hsync = (hst == H_SYNC);
        v_act = (vst == V_ACT);
        vsync = (vst == V_SYNC);
    end

    assert_hwrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tile_end && hc == HC_W'(HTOT - 1)) |=> (hc == '0));

    assert_hact_span_R2: assert property (@(posedge clk) disable iff (rst)
        (hst == H_ACT) |-> (hc < HC_W'(HACT)));

    assert_hsync_span_R3: assert property (@(posedge clk) disable iff (rst)
        (hst == H_SYNC) |-> (hc >= HC_W'(HACT + HS_START) &&
                             hc < HC_W'(HACT + HS_START + HS_TILES)));

    assert_hsync_tile_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (dot != '0) |-> $stable(hsync));

    assert_vwrap_R4: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (vc == '0));

    assert_vsync_span_R4: assert property (@(posedge clk) disable iff (rst)
        (vst == V_SYNC) |-> (vc >= VC_W'(VACT + VS_START) &&
                             vc < VC_W'(VACT + VS_START + VS_LINES)));
endmodule

// File: rtl/vid_fetch.sv
module vid_fetch
    import vid_pkg::*;
#(
    parameter int COL_BITS  = 6,
    parameter int ROW_BITS  = 5,
    parameter int TILE_BITS = 7
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              tile_end,
    input  logic [COL_BITS-1:0]               fetch_col,
    input  logic [ROW_BITS-1:0]               fetch_trow,
    input  logic [2:0]                        fetch_prow,
    input  logic                              map_we,
    input  logic [ROW_BITS+COL_BITS-1:0]      map_addr,
    input  logic [TILE_BITS-1:0]              map_data,
    input  logic                              pat_we,
    input  logic [1:0]                        pat_plane,
    input  logic [TILE_BITS+2:0]              pat_addr,
    input  logic [TILE_PX-1:0]                pat_data,
    output logic [NPLANES-1:0][TILE_PX-1:0]   pat_bytes
);
    localparam int MAP_DEPTH = 1 << (ROW_BITS + COL_BITS);
    localparam int PAT_DEPTH = 1 << (TILE_BITS + 3);

    logic [TILE_BITS-1:0] map_mem [MAP_DEPTH];
    logic [TILE_BITS-1:0] map_q;
    logic [TILE_BITS-1:0] tile_hold;

    // stage 1: tile-map read for the cell two periods ahead
    always_ff @(posedge clk) begin
        if (map_we) begin
            map_mem[map_addr] <= map_data;
        end
        map_q <= map_mem[{fetch_trow, fetch_col}];
    end

    // tile number held for one full period while the patterns are read
    always_ff @(posedge clk) begin
        if (rst) begin
            tile_hold <= '0;
        end else if (tile_end) begin
            tile_hold <= map_q;
        end
    end

    // stage 2: one pattern memory per colour plane
    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        logic [TILE_PX-1:0] pat_mem [PAT_DEPTH];
        logic [TILE_PX-1:0] pat_q;

        always_ff @(posedge clk) begin
            if (pat_we && pat_plane == 2'(p)) begin
                pat_mem[pat_addr] <= pat_data;
            end
            pat_q <= pat_mem[{tile_hold, fetch_prow}];
        end

        assign pat_bytes[p] = pat_q;
    end
endmodule

// File: rtl/vid_shifter.sv
module vid_shifter
    import vid_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [TILE_PX-1:0] din,
    output logic               dout
);
    logic [TILE_PX-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= din;
        end else begin
            sr <= {sr[TILE_PX-2:0], 1'b0};
        end
    end

    assign dout = sr[TILE_PX-1];
endmodule

// File: rtl/tile_video_pipe.sv
module tile_video_pipe
    import vid_pkg::*;
#(
    parameter int COL_BITS   = 6,
    parameter int ROW_BITS   = 5,
    parameter int TILE_BITS  = 7,
    parameter int VTOT_LINES = 288,
    parameter int HS_START   = 2,
    parameter int HS_TILES   = 12,
    parameter int VS_START   = 4,
    parameter int VS_LINES   = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         map_we,
    input  logic [ROW_BITS+COL_BITS-1:0] map_addr,
    input  logic [TILE_BITS-1:0]         map_data,
    input  logic                         pat_we,
    input  logic [1:0]                   pat_plane,
    input  logic [TILE_BITS+2:0]         pat_addr,
    input  logic [7:0]                   pat_data,
    output logic [3:0]                   rgbi,
    output logic                         hsync,
    output logic                         vsync,
    output logic                         blank
);
    logic                             tile_end;
    logic                             h_act;
    logic                             v_act;
    logic [COL_BITS-1:0]              fetch_col;
    logic [ROW_BITS-1:0]              fetch_trow;
    logic [2:0]                       fetch_prow;
    logic [NPLANES-1:0][TILE_PX-1:0]  pat_bytes;
    logic [NPLANES-1:0]               plane_bit;

    vid_timing #(
        .COL_BITS  (COL_BITS),
        .ROW_BITS  (ROW_BITS),
        .VTOT_LINES(VTOT_LINES),
        .HS_START  (HS_START),
        .HS_TILES  (HS_TILES),
        .VS_START  (VS_START),
        .VS_LINES  (VS_LINES)
    ) u_timing (
        .clk       (clk),
        .rst       (rst),
        .tile_end  (tile_end),
        .h_act     (h_act),
        .v_act     (v_act),
        .hsync     (hsync),
        .vsync     (vsync),
        .fetch_col (fetch_col),
        .fetch_trow(fetch_trow),
        .fetch_prow(fetch_prow)
    );

    vid_fetch #(
        .COL_BITS (COL_BITS),
        .ROW_BITS (ROW_BITS),
        .TILE_BITS(TILE_BITS)
    ) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .tile_end  (tile_end),
        .fetch_col (fetch_col),
        .fetch_trow(fetch_trow),
        .fetch_prow(fetch_prow),
        .map_we    (map_we),
        .map_addr  (map_addr),
        .map_data  (map_data),
        .pat_we    (pat_we),
        .pat_plane (pat_plane),
        .pat_addr  (pat_addr),
        .pat_data  (pat_data),
        .pat_bytes (pat_bytes)
    );

    // parallel load of all planes on the last dot of each tile
    for (genvar p = 0; p < NPLANES; p++) begin : g_shift
        vid_shifter u_shifter (
            .clk (clk),
            .rst (rst),
            .load(tile_end),
            .din (pat_bytes[p]),
            .dout(plane_bit[p])
        );
    end

    always_comb begin
        blank = !(h_act && v_act);
        rgbi  = blank ? 4'b0000 : plane_bit;
    end

    assert_hsync_in_blank_R3: assert property (@(posedge clk) disable iff (rst)
        hsync |-> blank);

    assert_vsync_in_blank_R4: assert property (@(posedge clk) disable iff (rst)
        vsync |-> blank);
endmodule

// File: tb/tile_video_pipe_bench.sv
module tile_video_pipe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CB   = 4;
    localparam int RB   = 2;
    localparam int TB   = 7;
    localparam int VT   = 40;
    localparam int HSS  = 2;
    localparam int HST  = 3;
    localparam int VSS  = 2;
    localparam int VSL  = 2;
    localparam int HACT = 1 << CB;
    localparam int HTOT = 3 << (CB - 1);
    localparam int VACT = 8 << RB;
    localparam int LD   = HTOT * 8;
    localparam int FD   = LD * VT;
    localparam int WATCHDOG = 100000;

    typedef struct packed {
        logic [3:0] rgbi;
        logic       hs;
        logic       vs;
        logic       bl;
        logic [3:0] tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             map_we = 1'b0;
    logic [RB+CB-1:0] map_addr = '0;
    logic [TB-1:0]    map_data = '0;
    logic             pat_we = 1'b0;
    logic [1:0]       pat_plane = '0;
    logic [TB+2:0]    pat_addr = '0;
    logic [7:0]       pat_data = '0;
    logic [3:0]       rgbi;
    logic             hsync;
    logic             vsync;
    logic             blank;

    int   checks = 0;
    int   errors = 0;
    int   pos = 0;
    exp_t expq[$];
    exp_t cur;
    int   cur_ln;
    int   mdl_map [0:(VACT/8)*HACT-1];
    logic [7:0] mdl_pat [0:3][0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_video_pipe #(
        .COL_BITS(CB), .ROW_BITS(RB), .TILE_BITS(TB), .VTOT_LINES(VT),
        .HS_START(HSS), .HS_TILES(HST), .VS_START(VSS), .VS_LINES(VSL)
    ) u_tile_video_pipe (
        .clk(clk), .rst(rst),
        .map_we(map_we), .map_addr(map_addr), .map_data(map_data),
        .pat_we(pat_we), .pat_plane(pat_plane), .pat_addr(pat_addr), .pat_data(pat_data),
        .rgbi(rgbi), .hsync(hsync), .vsync(vsync), .blank(blank)
    );

    // dot index since reset release, matches the design's dot count
    always @(posedge clk) begin
        if (rst) pos <= 0;
        else     pos <= pos + 1;
    end

    task automatic chk(string tag, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s at dot %0d actual %0h expected %0h", tag, what, pos, act, expv);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] pbyte(int p, int t, int y);
        if (t == 0) return 8'h00;
        if (t == 7) return 8'hFF;
        return 8'((t * 37 + y * 29 + p * 71) ^ (y * 16 + t));
    endfunction

    task automatic wr_map(int r, int c, int t);
        @(negedge clk);
        pat_we   = 1'b0;
        map_we   = 1'b1;
        map_addr = (RB+CB)'(r * HACT + c);
        map_data = TB'(t);
        mdl_map[r * HACT + c] = t;
    endtask

    task automatic wr_pat(int p, int t, int y, logic [7:0] v);
        @(negedge clk);
        map_we    = 1'b0;
        pat_we    = 1'b1;
        pat_plane = 2'(p);
        pat_addr  = (TB+3)'(t * 8 + y);
        pat_data  = v;
        mdl_pat[p][t * 8 + y] = v;
    endtask

    task automatic wr_idle();
        @(negedge clk);
        map_we = 1'b0;
        pat_we = 1'b0;
    endtask

    task automatic wait_pos(int p);
        while (pos < p) @(negedge clk);
    endtask

    // driver: expected stream of one whole frame from the bench model
    task automatic push_frame();
        exp_t e;
        int   tl;
        int   r;
        for (int ln = 0; ln < VT; ln++) begin
            for (int h = 0; h < HTOT; h++) begin
                for (int d = 0; d < 8; d++) begin
                    e.bl   = !(h < HACT && ln < VACT);                        // R2, R4
                    e.hs   = (h >= HACT + HSS) && (h < HACT + HSS + HST);     // R3
                    e.vs   = (ln >= VACT + VSS) && (ln < VACT + VSS + VSL);   // R4
                    e.rgbi = 4'b0000;                                         // R6 when blank
                    e.tag  = 4'd5;
                    if (!e.bl) begin
                        r  = ln / 8;
                        tl = mdl_map[r * HACT + h];
                        for (int p = 0; p < 4; p++) begin
                            e.rgbi[p] = mdl_pat[p][tl * 8 + ln % 8][7 - d];  // R5
                        end
                        if ((r == 0 && h == 3) || r == 3 || (r == 1 && h == 0)) e.tag = 4'd7;
                        else if ((tl == 6 && ln % 8 == 1) || tl == 1)           e.tag = 4'd8;
                    end
                    expq.push_back(e);
                end
            end
        end
    endtask

    // monitor: pop one expected item per dot of frames 1 to 3
    always @(negedge clk) begin
        if (!rst && pos >= FD && pos < 4 * FD) begin
            if (expq.size() == 0) begin
                chk("R2", 0, 1, "scoreboard empty");
            end else begin
                cur    = expq.pop_front();
                cur_ln = (pos / LD) % VT;
                chk("R3", int'(hsync), int'(cur.hs), "hsync");
                chk("R4", int'(vsync), int'(cur.vs), "vsync");
                chk((cur_ln < VACT) ? "R2" : "R4", int'(blank), int'(cur.bl), "blank");
                if (cur.bl)              chk("R6", int'(rgbi), int'(cur.rgbi), "rgbi");
                else if (cur.tag == 4'd7) chk("R7", int'(rgbi), int'(cur.rgbi), "rgbi");
                else if (cur.tag == 4'd8) chk("R8", int'(rgbi), int'(cur.rgbi), "rgbi");
                else                     chk("R5", int'(rgbi), int'(cur.rgbi), "rgbi");
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk("R2", 0, 1, "watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: values held in reset
        chk("R1", int'(rgbi), 0, "rgbi in reset");
        chk("R1", int'(hsync), 0, "hsync in reset");
        chk("R1", int'(vsync), 0, "vsync in reset");
        chk("R1", int'(blank), 0, "blank in reset");
        rst = 1'b0;
        #1;
        // R1: first dot after release
        chk("R1", int'(rgbi), 0, "rgbi after release");
        chk("R1", int'(hsync), 0, "hsync after release");
        chk("R1", int'(blank), 0, "blank after release");

        // frame 0: fill map and patterns (unchecked frame)
        for (int r = 0; r < VACT / 8; r++)
            for (int c = 0; c < HACT; c++)
                wr_map(r, c, (r * 3 + c) % 8);
        for (int p = 0; p < 4; p++)
            for (int t = 0; t < 8; t++)
                for (int y = 0; y < 8; y++)
                    wr_pat(p, t, y, pbyte(p, t, y));
        wr_idle();
        wait_pos(FD - 200);
        push_frame();

        // frame 1: writes while the picture streams, to resources already read (R7, R8)
        wait_pos(FD + 28 * LD + 5);
        wr_map(0, 3, 5);
        wr_pat(2, 6, 1, 8'h5A);
        wr_idle();

        // vertical blank of frame 1: red plane of tile 1 changes (R8)
        wait_pos(2 * FD - 600);
        for (int y = 0; y < 8; y++) wr_pat(3, 1, y, 8'hF0 ^ 8'(y));
        wr_idle();
        push_frame();

        // vertical blank of frame 2: row 3 goes white, one cell goes dark (R7)
        wait_pos(3 * FD - 600);
        for (int c = 0; c < HACT; c++) wr_map(3, c, 7);
        wr_map(1, 0, 0);
        wr_idle();
        push_frame();

        wait_pos(4 * FD + 4);
        chk("R4", expq.size(), 0, "items left in scoreboard");
        summary();
    end
endmodule